// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit-Slip Alignment

The block turns a serial bit stream, captured one bit per rising edge of a bit-rate clock, into 4-bit parallel words. Bits are packed least significant first. Each new word is marked by a one-cycle strobe, and a derived word clock is provided for the downstream logic. A mode input selects a word clock at one quarter of the bit rate, or a half-rate word clock for double-data-rate capture. In that mode a new word appears on every edge of the word clock.

A slip request input aligns the word boundary to the framing of the incoming stream. The input may arrive from any clock domain. Each rising edge of the request, once synchronised, removes exactly one serial bit from the output stream. The bit dropped is the first bit that would have started the next word, so the boundary moves one bit earlier in time. Requests that arrive while earlier ones are still waiting are queued and spent one per word boundary.

Control is a two-state machine. In state ST_RUN the block shifts in a bit every cycle and counts bit positions 0 to 3. Transition RUN_TO_RUN is taken on every bit. At position 3 it becomes LOAD_TO_RUN, which copies the word out when no slip is queued. Transition LOAD_TO_SKIP copies the word out and enters ST_SKIP when at least one slip is queued. In ST_SKIP the incoming bit is discarded and the bit counter is held at 0. Transition SKIP_TO_RUN always follows after one bit period, so a slipped boundary spans five bit times.

Top module: `deser4_slip`

## Requirements
- R1: Serial bits are packed least significant first: of the four bits making a word, the first captured appears on word_out[0], the next on word_out[1], and the fourth on word_out[3].
- R2: word_stb is high for exactly one cycle, the cycle that follows the edge at which word_out takes a new word. word_out holds its value in every other cycle. The first word (the first four bits after reset release) is loaded at the fourth rising edge after reset is released. Without slips, a new word follows every four edges.
- R3: While the synchronous active-high rst is sampled high, word_out, word_stb and word_clk are all 0 after the edge, and the bit count restarts at position 0.
- R4: An applied slip discards exactly one serial bit: the bit captured at the edge right after a word load. The next word is built from the four bits that follow it, so that boundary spans five bit times.
- R5: With the default two synchroniser stages, a slip_req rising edge that is present before rising edge a is queued at edge a+2. It is applied at the first word load that happens at or after edge a+3.
- R6: One slip is counted per rising edge of slip_req, however long the input then stays high. A request must be held high, and then low, for at least two clock cycles each.
- R7: Requests that arrive before earlier ones are applied are queued, up to three outstanding. Exactly one queued request is applied per word load, so each drops its own bit at a separate boundary.
- R8: With ddr_mode = 0, word_clk goes high at each word load. It stays high through the following bit period and, when a slip follows, through the skipped period as well. It is low for the rest of the word, which gives a period of four bits without slips.
- R9: With ddr_mode = 1, word_clk inverts at every word load and at no other time. Its period is eight bits without slips, and successive words begin on alternate edges of word_clk.
- R10: For input bits D0..D8 after reset, with one slip request raised at reset release and held three cycles, the first word is D0..D3 and the second word is D5..D8 (D4 is removed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, rising edge samples ser_in |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| slip_req | input | 1 | Asynchronous slip request, rising-edge counted |
| ddr_mode | input | 1 | 0: quarter-rate word clock, 1: half-rate word clock toggling per word |
| word_out | output | WORD_W | Parallel word, first serial bit in bit 0 |
| word_stb | output | 1 | One-cycle strobe marking a new word |
| word_clk | output | 1 | Derived word clock for downstream capture |

## Verification
The assertions assume three things about the inputs. slip_req stays at each level for at least two bit clocks. ddr_mode changes only while rst is high. rst is asserted from the first edge, so the synchroniser and the word clock start from known values. The stimulus follows all three rules: inputs change only on the falling clock edge, every slip pulse and every gap between pulses is at least two cycles long, and each switch between normal and double-data-rate modes sits inside a reset. The slip sweeps place the request at every bit offset within a word. This covers the corner where a request becomes pending only one edge before a load.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Control state of the word assembler.
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,   // shifting one bit per cycle
        ST_SKIP = 1'b1    // discarding one bit for a slip
    } dsr_state_t;

    // Clock derivation variants selected by the mode input.
    typedef enum logic [0:0] {
        WCLK_QUARTER = 1'b0,
        WCLK_HALF    = 1'b1
    } wclk_mode_t;

endpackage

// File: rtl/dsr_slip_sync.sv
module dsr_slip_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slip_req,
    output logic slip_pls
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_q;

    // Synchroniser chain, one flop per stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= 1'b0;
        end else begin
            chain[0] <= slip_req;
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= 1'b0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Edge memory for rising-edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain[LAST];
        end
    end

    always_comb begin
        slip_pls = chain[LAST] & ~prev_q;
    end

    AST_ONE_PULSE_PER_RISE: assert property (@(posedge clk) disable iff (rst)
        slip_pls |=> !slip_pls); // R6

endmodule

// File: rtl/dsr_word_fsm.sv
module dsr_word_fsm
    import deser_pkg::*;
#(
    parameter int WORD_W = 4,
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slip_pls,
    output logic shift_en,
    output logic load,
    output logic in_skip,
    output logic first_bit
);
    localparam int                CNT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;
    localparam int                PEND_MAX = (1 << PEND_W) - 1;

    dsr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic             take;
    logic [PEND_W:0]  pend_sum;

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_ZERO;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // Next-state and counter process.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        take    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (cnt_q == CNT_LAST) begin
                    cnt_d = CNT_ZERO;
                    if (pend_q != '0) begin
                        state_d = ST_SKIP;   // LOAD_TO_SKIP
                        take    = 1'b1;
                    end else begin
                        state_d = ST_RUN;    // LOAD_TO_RUN
                    end
                end else begin
                    cnt_d   = cnt_q + 1'b1;  // RUN_TO_RUN
                    state_d = ST_RUN;
                end
            end
            ST_SKIP: begin
                cnt_d   = CNT_ZERO;          // SKIP_TO_RUN
                state_d = ST_RUN;
            end
            default: begin
                cnt_d   = CNT_ZERO;
                state_d = ST_RUN;
            end
        endcase
    end

    // Slip queue: one request in per pulse, one out per applied slip.
    always_comb begin
        pend_sum = {1'b0, pend_q} - {{PEND_W{1'b0}}, take}
                                  + {{PEND_W{1'b0}}, slip_pls};
        if (pend_sum > (PEND_W+1)'(PEND_MAX)) begin
            pend_d = PEND_W'(PEND_MAX);
        end else begin
            pend_d = pend_sum[PEND_W-1:0];
        end
    end

    // Output process.
    always_comb begin
        shift_en  = 1'b0;
        load      = 1'b0;
        in_skip   = 1'b0;
        first_bit = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                shift_en  = 1'b1;
                load      = (cnt_q == CNT_LAST);
                first_bit = (cnt_q == CNT_ZERO);
            end
            ST_SKIP: begin
                in_skip = 1'b1;
            end
            default: begin
                in_skip = 1'b0;
            end
        endcase
    end

    AST_SKIP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SKIP) |=> (state_q == ST_RUN)); // R4

    AST_SKIP_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SKIP) |-> $past(load)); // R4

    AST_SKIP_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_SKIP) |-> ($past(pend_q) != '0)); // R7

endmodule

// File: rtl/dsr_word_path.sv
module dsr_word_path
    import deser_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    input  logic              ddr_mode,
    input  logic              shift_en,
    input  logic              load,
    input  logic              in_skip,
    input  logic              first_bit,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              word_clk
);
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] next_word;
    logic              wclk_d;
    wclk_mode_t        wmode;

    // New bit enters at the top; the oldest bit ends at bit 0.
    always_comb begin
        if (WORD_W > 1) begin
            next_word = {ser_bit, shreg_q[WORD_W-1:1]};
        end else begin
            next_word = WORD_W'(ser_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (shift_en) begin
            shreg_q <= next_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= load;
            if (load) begin
                word_out <= next_word;
            end
        end
    end

    // Word clock derivation.
    always_comb begin
        wmode = ddr_mode ? WCLK_HALF : WCLK_QUARTER;
        unique case (wmode)
            WCLK_HALF: begin
                wclk_d = word_clk ^ load;
            end
            WCLK_QUARTER: begin
                if (load) begin
                    wclk_d = 1'b1;
                end else if (in_skip || first_bit) begin
                    wclk_d = word_clk;
                end else begin
                    wclk_d = 1'b0;
                end
            end
            default: wclk_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_clk <= 1'b0;
        end else begin
            word_clk <= wclk_d;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb); // R2

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(word_out)); // R2

    AST_NORM_CLK_RISE: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && $rose(word_clk)) |-> word_stb); // R8

    AST_DDR_CLK_FLIP: assert property (@(posedge clk) disable iff (rst)
        ($past(ddr_mode) && word_stb) |-> (word_clk != $past(word_clk))); // R9

endmodule

// File: rtl/deser4_slip.sv
module deser4_slip
    import deser_pkg::*;
#(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PEND_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              slip_req,
    input  logic              ddr_mode,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              word_clk
);
    logic slip_pls;
    logic shift_en;
    logic load;
    logic in_skip;
    logic first_bit;

    dsr_slip_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .slip_req (slip_req),
        .slip_pls (slip_pls)
    );

    dsr_word_fsm #(
        .WORD_W (WORD_W),
        .PEND_W (PEND_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .slip_pls  (slip_pls),
        .shift_en  (shift_en),
        .load      (load),
        .in_skip   (in_skip),
        .first_bit (first_bit)
    );

    dsr_word_path #(
        .WORD_W (WORD_W)
    ) u_path (
        .clk       (clk),
        .rst       (rst),
        .ser_bit   (ser_in),
        .ddr_mode  (ddr_mode),
        .shift_en  (shift_en),
        .load      (load),
        .in_skip   (in_skip),
        .first_bit (first_bit),
        .word_out  (word_out),
        .word_stb  (word_stb),
        .word_clk  (word_clk)
    );

    AST_LOAD_NOT_IN_SKIP: assert property (@(posedge clk) disable iff (rst)
        in_skip |=> !word_stb); // R4

endmodule

// File: tb/sim_deser4_slip.sv
`timescale 1ns/1ps
module sim_deser4_slip;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       slip_req = 1'b0;
    logic       ddr_mode = 1'b0;
    logic [3:0] word_out;
    logic       word_stb;
    logic       word_clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    // bench model of the requirements
    logic [3:0] m_acc, exp_word;
    int  m_cnt, m_pend;
    bit  m_skip, m_s1, m_s2, m_s3, exp_stb, exp_clk, m_ddr;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    deser4_slip u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .slip_req(slip_req),
        .ddr_mode(ddr_mode), .word_out(word_out), .word_stb(word_stb),
        .word_clk(word_clk)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit next_bit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    // Drive one bit, predict the state after the coming edge, then check.
    task automatic step(input bit b, input bit sl);
        bit pulse, load, was_skip, first;
        ser_in   = b;
        slip_req = sl;
        pulse = m_s2 & ~m_s3;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = sl;
        load = 0; first = 0; was_skip = m_skip; exp_stb = 0;
        if (m_skip) begin
            m_skip = 0;
        end else begin
            m_acc[m_cnt] = b;
            if (m_cnt == 3) begin
                load = 1; exp_word = m_acc; exp_stb = 1; m_cnt = 0;
                if (m_pend > 0) begin m_skip = 1; m_pend--; end
            end else begin
                first = (m_cnt == 0);
                m_cnt++;
            end
        end
        m_pend = m_pend + int'(pulse);
        if (m_pend > 3) m_pend = 3;
        if (m_ddr) exp_clk = exp_clk ^ load;
        else if (load) exp_clk = 1;
        else if (!(was_skip || first)) exp_clk = 0;
        @(negedge clk);
        chk(cur_req, "word_out", 32'(word_out), 32'(exp_word));
        chk("R2", "word_stb", 32'(word_stb), 32'(exp_stb));
        if (m_ddr) chk("R9", "word_clk", 32'(word_clk), 32'(exp_clk));
        else       chk("R8", "word_clk", 32'(word_clk), 32'(exp_clk));
    endtask

    task automatic do_reset(input bit mode);
        rst = 1'b1; slip_req = 1'b0; ddr_mode = mode;
        repeat (3) @(negedge clk);
        chk("R3", "word_out in reset", 32'(word_out), 32'h0);
        chk("R3", "word_stb in reset", 32'(word_stb), 32'h0);
        chk("R3", "word_clk in reset", 32'(word_clk), 32'h0);
        m_acc = '0; exp_word = '0; m_cnt = 0; m_pend = 0; m_skip = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0; exp_stb = 0; exp_clk = 0; m_ddr = mode;
        rst = 1'b0;
    endtask

    task automatic run_bits(input int n, input int slip_at, input int slip_len);
        for (int i = 0; i < n; i++)
            step(next_bit(), (i >= slip_at) && (i < slip_at + slip_len));
    endtask

    initial begin
        logic [8:0] dx;
        logic [3:0] w1;
        do_reset(1'b0);

        // R10: worked example, slip raised at reset release
        cur_req = "R10";
        dx = 9'b011010110;
        for (int i = 0; i < 9; i++) begin
            step(dx[i], i < 3);
            if (i == 3) w1 = word_out;
        end
        chk("R10", "first word", 32'(w1), 32'(dx[3:0]));
        chk("R10", "second word", 32'(word_out), 32'(dx[8:5]));
        run_bits(12, -1, 0);

        // R1: every word value, both modes
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            cur_req = "R1";
            for (int v = 0; v < 16; v++) begin
                for (int k = 0; k < 4; k++) step(v[k], 1'b0);
                chk("R1", "word value", 32'(word_out), 32'(v));
            end
        end

        // R4 / R5: slip at each bit offset in a word, both modes
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            cur_req = "R5";
            for (int off = 0; off < 8; off++) begin
                run_bits(off, -1, 0);
                cur_req = "R4";
                run_bits(24, 0, 3);
                cur_req = "R5";
            end
        end

        // R6: one long request drops one bit only
        do_reset(1'b0);
        cur_req = "R6";
        run_bits(10, -1, 0);
        run_bits(60, 2, 40);

        // R7: requests queued faster than boundaries
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            cur_req = "R7";
            run_bits(5, -1, 0);
            for (int p = 0; p < 5; p++) run_bits(4, 0, 2);
            run_bits(40, -1, 0);
        end

        // R3: reset mid-stream restarts alignment
        cur_req = "R3";
        run_bits(6, -1, 0);
        do_reset(1'b0);
        run_bits(16, -1, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule